// File: doc/BRIEF.md
# SPI Clock and Chip-Select Timing Generator

This block turns a fast reference clock into the serial clock and active-low chip-select waveforms used by a serial flash controller. A neighbouring shifter asks for a transaction with a one-cycle `xfer_start` pulse. The generator then asserts chip select, waits out the programmed setup time, and toggles the serial clock at the divided rate. It gives the shifter one-cycle `launch` and `sample` strobes that line up with the clock edges. After `xfer_end`, the clock stops at the next trailing edge. Chip select is released after the hold time.

Between transactions the block keeps chip select high for a programmed minimum. That minimum is longer when the next transaction targets a different device. The chip-select field is either passed through unchanged for an external decoder or turned into a one-hot active-low select. Configuration is changed only while `enable` is low. An `idle` output tells software when the block has fully settled.

Top module: `spi_cs_timing_gen`

## Requirements
- R1: With divider value d (0 to 2^DIV_W-1, largest 15 by default), each SCLK level between consecutive edges of a transaction lasts d+1 reference cycles, so SCLK runs at the reference rate divided by 2*(d+1).
- R2: Whenever no chip select is asserted, SCLK sits at `cfg_cpol`, and the first edge of a transaction moves away from that level.
- R3: With `cfg_decode`=1, `cs_n` equals `cfg_cs` unchanged for the whole time chip select is asserted.
- R4: With `cfg_decode`=0, the low log2(CS_W) bits of `cfg_cs` give an index n, and `cs_n` drives line n low with all other lines high; for example, index 2 gives 4'b1011 and index 0 gives 4'b1110. The upper bits of `cfg_cs` are ignored.
- R5: With `cfg_cpha`=0, `launch` pulses in the cycle chip select asserts and at every trailing edge except the last, and `sample` pulses at every leading edge. With `cfg_cpha`=1, `launch` pulses at every leading edge and `sample` at every trailing edge. Each pulse lasts one cycle, the two never coincide, and an edge strobe appears in the same cycle as the SCLK change.
- R6: An `xfer_end` pulse, accepted while chip select is asserted, stops SCLK after the next trailing edge, so a transaction always holds whole clock periods.
- R7: The first SCLK edge comes `cfg_setup`+1 reference cycles after `cs_n` goes active.
- R8: `cs_n` returns high `cfg_hold`+1 reference cycles after the last SCLK edge.
- R9: A new assertion follows a deassertion by at least `cfg_gap`+1 cycles of chip select high when the select pattern is the same, and by at least `cfg_switch`+1 cycles when it differs. A start that arrives earlier is held until the spacing is met.
- R10: `idle` is high only when no transaction is pending or active, chip select is deasserted, and at least max(`cfg_gap`,`cfg_switch`) cycles have passed since deassertion. It rises exactly that many cycles after `cs_n` rises, and it is high straight after reset.
- R11: While `enable` is low, SCLK is at `cfg_cpol`, all `cs_n` lines are high, `xfer_start` is ignored, and any active transaction is abandoned within one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; configuration changes only while low |
| cfg_div | input | DIV_W | Baud divider d |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_cs | input | CS_W | Chip-select field |
| cfg_decode | input | 1 | 1: pass field to external decoder, 0: one-hot select |
| cfg_setup | input | DLY_W | Chip-select-to-first-edge delay |
| cfg_hold | input | DLY_W | Last-edge-to-deselect delay |
| cfg_gap | input | DLY_W | Minimum deselect time, same device |
| cfg_switch | input | DLY_W | Minimum deselect time, different device |
| xfer_start | input | 1 | One-cycle transaction request |
| xfer_end | input | 1 | One-cycle end request |
| sclk | output | 1 | Serial clock |
| cs_n | output | CS_W | Active-low chip select |
| launch | output | 1 | Shifter strobe: drive next bit |
| sample | output | 1 | Shifter strobe: capture a bit |
| idle | output | 1 | Block fully idle |

## Verification
The bench builds the block with its default widths: a 4-bit divider, 8-bit delays and a 4-line chip select. This puts both extremes in reach at small cost. The largest divider of 15 gives 16-cycle half periods, and the largest setup delay of 255 gives 256 cycles. Divider 0 exercises the back-to-back edge path, where an end request must land in the same cycle as a toggle. The 4-line select covers every one-hot index, an ignored upper bit, and a raw decoder pattern.

// File: rtl/spi_tgen_pkg.sv
package spi_tgen_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_SETUP,
      ST_RUN,
      ST_HOLD
   } tgen_state_e;
endpackage

// File: rtl/spi_tgen_baud.sv
module spi_tgen_baud #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] phase;

   assign tick = run && (phase == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (!run || tick)
         phase <= '0;
      else
         phase <= phase + 1'b1;
   end
endmodule

// File: rtl/spi_tgen_dly.sv
module spi_tgen_dly #(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] val,
   output logic             zero
);
   logic [DLY_W-1:0] cnt;

   assign zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= val;
      else if (!zero)
         cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/spi_tgen_csenc.sv
module spi_tgen_csenc #(
   parameter int CS_W = 4
) (
   input  logic            decode,
   input  logic [CS_W-1:0] cs_in,
   output logic [CS_W-1:0] pat
);
   localparam int IDX_W = $clog2(CS_W);

   logic [IDX_W-1:0] idx;
   assign idx = cs_in[IDX_W-1:0];

   for (genvar i = 0; i < CS_W; i++) begin : g_line
      assign pat[i] = decode ? cs_in[i] : (idx != IDX_W'(i));
   end
endmodule

// File: rtl/spi_cs_timing_gen.sv
module spi_cs_timing_gen
   import spi_tgen_pkg::*;
#(
   parameter int DIV_W = 4,
   parameter int DLY_W = 8,
   parameter int CS_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_cpol,
   input  logic             cfg_cpha,
   input  logic [CS_W-1:0]  cfg_cs,
   input  logic             cfg_decode,
   input  logic [DLY_W-1:0] cfg_setup,
   input  logic [DLY_W-1:0] cfg_hold,
   input  logic [DLY_W-1:0] cfg_gap,
   input  logic [DLY_W-1:0] cfg_switch,
   input  logic             xfer_start,
   input  logic             xfer_end,
   output logic             sclk,
   output logic [CS_W-1:0]  cs_n,
   output logic             launch,
   output logic             sample,
   output logic             idle
);
   localparam logic [DLY_W-1:0] DESEL_MAX = '1;

   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end
   if (DLY_W < 1) begin : g_bad_dly
      $error("DLY_W must be at least 1");
   end
   if ((CS_W < 2) || ((CS_W & (CS_W - 1)) != 0)) begin : g_bad_cs
      $error("CS_W must be a power of two of at least 2");
   end

   tgen_state_e      st;
   logic             ph_hi;
   logic [CS_W-1:0]  cur_pat;
   logic [CS_W-1:0]  enc_pat;
   logic [DLY_W-1:0] desel;
   logic             end_req;

   logic in_setup, in_run, in_hold, cs_act;
   logic tick_run, dly_zero, dly_load;
   logic spaced, go_setup, go_hold, end_eff;
   logic [DLY_W-1:0] need_gap, dly_val;

   assign in_setup = (st == ST_SETUP);
   assign in_run   = (st == ST_RUN);
   assign in_hold  = (st == ST_HOLD);
   assign cs_act   = in_setup || in_run || in_hold;

   spi_tgen_csenc #(.CS_W(CS_W)) u_enc (
      .decode (cfg_decode),
      .cs_in  (cfg_cs),
      .pat    (enc_pat)
   );

   spi_tgen_baud #(.DIV_W(DIV_W)) u_baud (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (in_run && enable),
      .div   (cfg_div),
      .tick  (tick_run)
   );

   assign need_gap = (enc_pat == cur_pat) ? cfg_gap : cfg_switch;
   assign spaced   = (desel >= need_gap);
   assign go_setup = enable && spaced &&
                     (((st == ST_IDLE) && xfer_start) || (st == ST_WAIT));
   assign end_eff  = end_req || xfer_end;
   assign go_hold  = enable && in_run && tick_run && ph_hi && end_eff;
   assign dly_load = go_setup || go_hold;
   assign dly_val  = go_setup ? cfg_setup : cfg_hold;

   spi_tgen_dly #(.DLY_W(DLY_W)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (dly_load),
      .val   (dly_val),
      .zero  (dly_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         ph_hi   <= 1'b0;
         cur_pat <= '1;
         end_req <= 1'b0;
         launch  <= 1'b0;
         sample  <= 1'b0;
         desel   <= DESEL_MAX;
      end else begin
         launch <= 1'b0;
         sample <= 1'b0;
         if (cs_act)
            desel <= '0;
         else if (desel != DESEL_MAX)
            desel <= desel + 1'b1;

         if (!enable) begin
            st      <= ST_IDLE;
            ph_hi   <= 1'b0;
            end_req <= 1'b0;
         end else begin
            case (st)
               ST_IDLE, ST_WAIT: begin
                  if (go_setup) begin
                     st      <= ST_SETUP;
                     cur_pat <= enc_pat;
                     launch  <= ~cfg_cpha;
                  end else if ((st == ST_IDLE) && xfer_start) begin
                     st <= ST_WAIT;
                  end
               end
               ST_SETUP: begin
                  if (xfer_end)
                     end_req <= 1'b1;
                  if (dly_zero) begin
                     st     <= ST_RUN;
                     ph_hi  <= 1'b1;
                     sample <= ~cfg_cpha;
                     launch <= cfg_cpha;
                  end
               end
               ST_RUN: begin
                  if (xfer_end)
                     end_req <= 1'b1;
                  if (tick_run) begin
                     ph_hi <= ~ph_hi;
                     if (!ph_hi) begin
                        sample <= ~cfg_cpha;
                        launch <= cfg_cpha;
                     end else if (end_eff) begin
                        st      <= ST_HOLD;
                        end_req <= 1'b0;
                        sample  <= cfg_cpha;
                     end else begin
                        launch <= ~cfg_cpha;
                        sample <= cfg_cpha;
                     end
                  end
               end
               ST_HOLD: begin
                  if (dly_zero)
                     st <= ST_IDLE;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign sclk = ph_hi ^ cfg_cpol;
   assign cs_n = cs_act ? cur_pat : '1;
   assign idle = (st == ST_IDLE) && (desel >= cfg_gap) && (desel >= cfg_switch);
endmodule

// File: rtl/spi_cs_timing_gen_chk.sv
module spi_cs_timing_gen_chk #(
   parameter int DIV_W = 4,
   parameter int CS_W  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic [DIV_W-1:0] cfg_div,
   input logic             cfg_cpol,
   input logic [CS_W-1:0]  cfg_cs,
   input logic             cfg_decode,
   input logic             sclk,
   input logic [CS_W-1:0]  cs_n,
   input logic             launch,
   input logic             sample,
   input logic             idle,
   input logic             cs_act,
   input logic             in_run,
   input logic             in_hold
);
   localparam int HP_W = DIV_W + 1;

   logic            sclk_d;
   logic            armed;
   logic [HP_W-1:0] hp;
   logic            chg;

   assign chg = (sclk != sclk_d);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         armed  <= 1'b0;
         hp     <= '0;
      end else begin
         sclk_d <= sclk;
         if (chg) begin
            hp    <= HP_W'(1);
            armed <= in_run && enable;
         end else begin
            if (hp != '1)
               hp <= hp + 1'b1;
            armed <= armed && in_run && enable;
         end
      end
   end

   assert_half_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (chg && armed && enable && (in_run || in_hold)) |-> (hp == (HP_W'(cfg_div) + HP_W'(1))));

   assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (sclk == cfg_cpol));

   assert_decode_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && cfg_decode) |-> (cs_n == cfg_cs));

   assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && !cfg_decode) |-> ($countones(~cs_n) == 1));

   assert_pulse_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(launch && sample));

   assert_sample_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sample |-> chg);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (!cs_act && !launch && !sample));

   assert_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> ((cs_n == '1) && (sclk == cfg_cpol)));
endmodule

bind spi_cs_timing_gen spi_cs_timing_gen_chk #(.DIV_W(DIV_W), .CS_W(CS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .cfg_div    (cfg_div),
   .cfg_cpol   (cfg_cpol),
   .cfg_cs     (cfg_cs),
   .cfg_decode (cfg_decode),
   .sclk       (sclk),
   .cs_n       (cs_n),
   .launch     (launch),
   .sample     (sample),
   .idle       (idle),
   .cs_act     (cs_act),
   .in_run     (in_run),
   .in_hold    (in_hold)
);

// File: tb/spi_cs_timing_gen_tb.sv
`timescale 1ns/100ps
module spi_cs_timing_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [3:0] cfg_div = '0;
   logic       cfg_cpol = 1'b0;
   logic       cfg_cpha = 1'b0;
   logic [3:0] cfg_cs = '0;
   logic       cfg_decode = 1'b0;
   logic [7:0] cfg_setup = '0;
   logic [7:0] cfg_hold = '0;
   logic [7:0] cfg_gap = '0;
   logic [7:0] cfg_switch = '0;
   logic       xfer_start = 1'b0;
   logic       xfer_end = 1'b0;
   logic       sclk;
   logic [3:0] cs_n;
   logic       launch, sample, idle;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   spi_cs_timing_gen u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_div(cfg_div),
      .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_cs(cfg_cs),
      .cfg_decode(cfg_decode), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
      .cfg_gap(cfg_gap), .cfg_switch(cfg_switch), .xfer_start(xfer_start),
      .xfer_end(xfer_end), .sclk(sclk), .cs_n(cs_n), .launch(launch),
      .sample(sample), .idle(idle)
   );

   // monitor, sampled at the falling edge
   int cyc = 0;
   int t_csf, t_csr, t_first_e, t_last_e, t_first_l, t_first_s, t_idle;
   int n_edges, n_launch, n_sample, n_fall, min_hp, max_hp, idle_bad;
   logic [3:0] cs_val;
   logic prev_sclk = 1'b0;
   logic prev_idle = 1'b0;
   logic [3:0] prev_cs = 4'hF;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic mon_clear();
      n_edges = 0; n_launch = 0; n_sample = 0; min_hp = 1 << 30; max_hp = 0;
      t_first_l = -1; t_first_s = -1; idle_bad = 0; t_idle = -1;
   endtask

   initial begin
      n_fall = 0; t_csf = 0; t_csr = 0; t_first_e = 0; t_last_e = 0;
      cs_val = '1;
      mon_clear();
   end

   always @(negedge clk) begin
      if (cs_n != 4'hF && prev_cs == 4'hF) begin t_csf = cyc; cs_val = cs_n; n_fall++; end
      if (cs_n == 4'hF && prev_cs != 4'hF) t_csr = cyc;
      if (sclk != prev_sclk && rst_n) begin
         if (n_edges == 0) t_first_e = cyc;
         else begin
            if (cyc - t_last_e < min_hp) min_hp = cyc - t_last_e;
            if (cyc - t_last_e > max_hp) max_hp = cyc - t_last_e;
         end
         t_last_e = cyc;
         n_edges++;
      end
      if (launch) begin if (t_first_l < 0) t_first_l = cyc; n_launch++; end
      if (sample) begin if (t_first_s < 0) t_first_s = cyc; n_sample++; end
      if (idle && !prev_idle) t_idle = cyc;
      if (idle && cs_n != 4'hF) idle_bad++;
      prev_sclk = sclk; prev_idle = idle; prev_cs = cs_n;
   end

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic check(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg(int d, bit pol, bit pha, logic [3:0] cs, bit dec,
                      int su, int ho, int ga, int sw);
      step(); enable = 1'b0;
      cfg_div = 4'(d); cfg_cpol = pol; cfg_cpha = pha; cfg_cs = cs; cfg_decode = dec;
      cfg_setup = 8'(su); cfg_hold = 8'(ho); cfg_gap = 8'(ga); cfg_switch = 8'(sw);
      step(); enable = 1'b1; step();
   endtask

   task automatic start_pulse();
      xfer_start = 1'b1; step(); xfer_start = 1'b0;
   endtask

   task automatic run_txn(int n);
      int e0;
      e0 = n_edges;
      start_pulse();
      while (n_edges < e0 + 2 * n - 1) step();
      xfer_end = 1'b1; step(); xfer_end = 1'b0;
      while (cs_n != 4'hF) step();
   endtask

   task automatic t_reset();
      check("R11 cs_n after reset", int'(cs_n), 15);
      check("R2 sclk after reset", int'(sclk), 0);
      check("R10 idle after reset", int'(idle), 1);
      check("R5 no strobes after reset", int'(launch | sample), 0);
   endtask

   task automatic t_basic();
      cfg(1, 0, 0, 4'd2, 0, 2, 3, 1, 1);
      mon_clear();
      run_txn(3);
      check("R4 one-hot index 2", int'(cs_val), 4'b1011);
      check("R6 edge count 3 periods", n_edges, 6);
      check("R1 min half period d=1", min_hp, 2);
      check("R1 max half period d=1", max_hp, 2);
      check("R7 setup 2", t_first_e - t_csf, 3);
      check("R8 hold 3", t_csr - t_last_e, 4);
      check("R5 cpha0 launch count", n_launch, 3);
      check("R5 cpha0 sample count", n_sample, 3);
      check("R5 cpha0 launch at assert", t_first_l - t_csf, 0);
      check("R5 cpha0 sample at first edge", t_first_s - t_first_e, 0);
      step();
      check("R2 sclk rests low", int'(sclk), 0);
   endtask

   task automatic t_mode3();
      cfg(0, 1, 1, 4'b1010, 1, 0, 0, 0, 0);
      check("R2 sclk rests high", int'(sclk), 1);
      mon_clear();
      run_txn(2);
      check("R3 decoder pattern", int'(cs_val), 4'b1010);
      check("R1 half period d=0", max_hp, 1);
      check("R6 edge count 2 periods", n_edges, 4);
      check("R5 cpha1 launch at first edge", t_first_l - t_first_e, 0);
      check("R5 cpha1 sample at second edge", t_first_s - t_first_e, 1);
      check("R5 cpha1 sample count", n_sample, 2);
      check("R7 setup 0", t_first_e - t_csf, 1);
      check("R8 hold 0", t_csr - t_last_e, 1);
      step();
      check("R2 sclk back high", int'(sclk), 1);
   endtask

   task automatic t_max();
      cfg(15, 0, 0, 4'd0, 0, 255, 0, 0, 0);
      mon_clear();
      run_txn(1);
      check("R4 one-hot index 0", int'(cs_val), 4'b1110);
      check("R1 half period d=15", max_hp, 16);
      check("R7 setup 255", t_first_e - t_csf, 256);
      check("R8 hold 0 at d=15", t_csr - t_last_e, 1);
   endtask

   task automatic t_upper_bits();
      cfg(1, 0, 0, 4'b0111, 0, 0, 0, 0, 0);
      mon_clear(); run_txn(1);
      check("R4 one-hot index 3", int'(cs_val), 4'b0111);
      cfg(1, 0, 0, 4'b1110, 0, 0, 0, 0, 0);
      mon_clear(); run_txn(1);
      check("R4 upper bits ignored", int'(cs_val), 4'b1011);
   endtask

   task automatic t_spacing();
      int r, f0;
      cfg(1, 0, 0, 4'd1, 0, 1, 1, 5, 9);
      mon_clear();
      run_txn(1);
      r = t_csr; f0 = n_fall;
      start_pulse();
      while (n_fall == f0) step();
      check("R9 same device gap 5", t_csf - r, 6);
      xfer_end = 1'b1; step(); xfer_end = 1'b0;
      while (cs_n != 4'hF) step();
      r = t_csr; f0 = n_fall;
      enable = 1'b0; cfg_cs = 4'd2; step(); enable = 1'b1;
      start_pulse();
      while (n_fall == f0) step();
      check("R9 device switch 9", t_csf - r, 10);
      check("R4 switched device", int'(cs_val), 4'b1011);
      mon_clear();
      xfer_end = 1'b1; step(); xfer_end = 1'b0;
      while (cs_n != 4'hF) step();
      repeat (15) step();
      check("R10 idle delay max(gap,switch)", t_idle - t_csr, 9);
      check("R10 idle never with cs active", idle_bad, 0);
   endtask

   task automatic t_disable();
      int f0;
      cfg(1, 0, 0, 4'd1, 0, 0, 0, 0, 0);
      step(); enable = 1'b0; cfg_cpol = 1'b1;
      mon_clear(); f0 = n_fall;
      start_pulse();
      repeat (10) step();
      check("R11 start ignored when disabled", n_fall - f0, 0);
      check("R11 sclk at polarity when disabled", int'(sclk), 1);
      check("R11 cs high when disabled", int'(cs_n), 15);
      enable = 1'b1; cfg_cpol = 1'b0; step();
      mon_clear();
      start_pulse();
      while (n_edges < 1) step();
      enable = 1'b0; step();
      check("R11 abort releases cs", int'(cs_n), 15);
      check("R11 abort parks sclk", int'(sclk), 0);
      enable = 1'b1; step();
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_basic();
      t_mode3();
      t_max();
      t_upper_bits();
      t_spacing();
      t_disable();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule